// File: doc/BRIEF.md
# Strobe-Driven Shared Register Bus

This block moves one 8-bit word per clock from a bank of four source registers onto a single destination register. Every bit of the shared bus has its own 4-to-1 multiplexer. The block does not take an encoded select. It receives four mutually exclusive timing strobes, one per source. From these it derives the 2-bit bus select and the destination load enable. Raising exactly one strobe copies the matching source into the destination on the next rising clock edge. The source is left untouched.

Each source register has its own parallel-load port, so its contents can be preset. A swap request exchanges sources 1 and 2 in a single edge without a temporary register, because both registers capture values sampled before that edge. If more than one strobe is high in the same cycle, the destination is protected and an error flag is raised.

Top module: `strobe_bus_mover`

## Requirements
- R1: A synchronous active-high reset clears all four source registers, the destination register and the error flag to zero on the clock edge where it is sampled high.
- R2: When only timing bit i is high (bit 0 selects source 0, up to bit 3 for source 3), the destination equals the pre-edge value of source i after the next rising edge. The bus select is binary i: its upper bit is T2 OR T3 and its lower bit is T1 OR T3.
- R3: A transfer leaves every source register unchanged.
- R4: With all timing bits low, the destination keeps its value.
- R5: With two or more timing bits high, the destination is not loaded. The error flag reads 1 after that edge and returns to 0 after the next edge with at most one timing bit high.
- R6: When srcLoad bit i is high, source i takes srcData bits [8i+7:8i] on the next edge.
- R7: A swap request exchanges the contents of sources 1 and 2 in one edge, each taking the other's pre-edge value.
- R8: A parallel load of source 1 or 2 takes priority over a swap for that register. The other register of the pair still takes the swapped value.
- R9: A transfer and a parallel load of the same source in one cycle load the destination with the old, pre-edge source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| timing | input | 4 | Timing strobes, bit i requests a copy of source i |
| srcLoad | input | 4 | Per-source parallel-load enables |
| srcData | input | 32 | Packed parallel-load data, source i in bits [8i+7:8i] |
| swapReq | input | 1 | Exchange sources 1 and 2 |
| destQ | output | 8 | Destination register |
| srcQ | output | 32 | Packed source registers, source i in bits [8i+7:8i] |
| multiHotErr | output | 1 | Registered flag, high after a cycle with more than one strobe |

## Verification
A wrong select decode or a broken multiplexer bit shows up as a wrong destination value exactly one edge after a single strobe. Because of this, every source is preloaded with a distinct pattern before it is copied. A load enable that leaks through an idle or conflicting cycle shows up as a destination change at the next edge, and the error flag is compared in that same cycle. A source corrupted by a transfer, by a swap or by the swap-versus-load priority appears on the packed source view one edge later.

// File: rtl/bus_mover_pkg.sv
package bus_mover_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic destLoad;
    logic conflict;
    logic swapGo;
  } moveStrobes_t;
endpackage

// File: rtl/bus_mover_ctrl.sv
module bus_mover_ctrl
  import bus_mover_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] timing,
  input  logic               swapReq,
  output logic [SEL_W-1:0]   busSel,
  output moveStrobes_t       strobes,
  output logic               errQ
);

  logic anyHigh;
  logic atMostOne;

  // Each select bit ORs the timing strobes whose index has that bit set
  for (genvar b = 0; b < SEL_W; b++) begin : g_selBit
    always_comb begin
      busSel[b] = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (((i >> b) & 1) == 1) busSel[b] = busSel[b] | timing[i];
      end
    end
  end

  assign anyHigh   = |timing;
  assign atMostOne = $onehot0(timing);

  always_comb begin
    strobes.destLoad = anyHigh && atMostOne;
    strobes.conflict = anyHigh && !atMostOne;
    strobes.swapGo   = swapReq;
  end

  always_ff @(posedge clk) begin
    if (rst) errQ <= 1'b0;
    else     errQ <= strobes.conflict;
  end

  // R5: a conflicting cycle never produces a load strobe
  a_r5_conflict_blocks_load: assert property (@(posedge clk) disable iff (rst)
    strobes.conflict |-> !strobes.destLoad);

  // R5: the flag follows a multi-strobe cycle
  a_r5_flag_after_conflict: assert property (@(posedge clk) disable iff (rst)
    ($countones(timing) > 1) |=> errQ);

  // R2: a lone strobe always asks for a load
  a_r2_single_loads: assert property (@(posedge clk) disable iff (rst)
    ($countones(timing) == 1) |-> strobes.destLoad);

endmodule

// File: rtl/bus_mover_dp.sv
module bus_mover_dp
  import bus_mover_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned SWAP_A  = 1,
  parameter int unsigned SWAP_B  = 2,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned FLAT_W = NUM_SRC * WIDTH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   busSel,
  input  moveStrobes_t       strobes,
  input  logic [NUM_SRC-1:0] srcLoad,
  input  logic [FLAT_W-1:0]  srcData,
  output logic [WIDTH-1:0]   destQ,
  output logic [FLAT_W-1:0]  srcQ
);

  logic [WIDTH-1:0] srcReg [NUM_SRC];
  logic [WIDTH-1:0] busBits;

  // Source bank with parallel load and pairwise swap
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [WIDTH-1:0] nextVal;
    always_comb begin
      nextVal = srcReg[i];
      if (srcLoad[i]) begin
        nextVal = srcData[i*WIDTH +: WIDTH];
      end else if (strobes.swapGo && (i == SWAP_A)) begin
        nextVal = srcReg[SWAP_B];
      end else if (strobes.swapGo && (i == SWAP_B)) begin
        nextVal = srcReg[SWAP_A];
      end
    end
    always_ff @(posedge clk) begin
      if (rst) srcReg[i] <= '0;
      else     srcReg[i] <= nextVal;
    end
    assign srcQ[i*WIDTH +: WIDTH] = srcReg[i];
  end

  // One k-to-1 multiplexer per bus bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_busBit
    logic [NUM_SRC-1:0] column;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_col
      assign column[i] = srcReg[i][b];
    end
    assign busBits[b] = column[busSel];
  end

  always_ff @(posedge clk) begin
    if (rst)                   destQ <= '0;
    else if (strobes.destLoad) destQ <= busBits;
  end

  // R2: destination captures the bus word of the load cycle
  a_r2_dest_takes_bus: assert property (@(posedge clk) disable iff (rst)
    strobes.destLoad |=> (destQ == $past(busBits)));

  // R4: no load strobe, destination holds
  a_r4_dest_holds: assert property (@(posedge clk) disable iff (rst)
    !strobes.destLoad |=> $stable(destQ));

  // R3: without loads or swaps the sources never move
  a_r3_sources_untouched: assert property (@(posedge clk) disable iff (rst)
    (!(|srcLoad) && !strobes.swapGo) |=> $stable(srcQ));

  // R7: a swap with no preload exchanges the pair
  a_r7_swap_exchange: assert property (@(posedge clk) disable iff (rst)
    (strobes.swapGo && !srcLoad[SWAP_A] && !srcLoad[SWAP_B])
      |=> (srcReg[SWAP_A] == $past(srcReg[SWAP_B])));

endmodule

// File: rtl/strobe_bus_mover.sv
module strobe_bus_mover
  import bus_mover_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned WIDTH   = 8,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned FLAT_W = NUM_SRC * WIDTH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] timing,
  input  logic [NUM_SRC-1:0] srcLoad,
  input  logic [FLAT_W-1:0]  srcData,
  input  logic               swapReq,
  output logic [WIDTH-1:0]   destQ,
  output logic [FLAT_W-1:0]  srcQ,
  output logic               multiHotErr
);

  logic [SEL_W-1:0] busSel;
  moveStrobes_t     strobes;

  bus_mover_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .timing  (timing),
    .swapReq (swapReq),
    .busSel  (busSel),
    .strobes (strobes),
    .errQ    (multiHotErr)
  );

  bus_mover_dp #(.NUM_SRC(NUM_SRC), .WIDTH(WIDTH)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .busSel  (busSel),
    .strobes (strobes),
    .srcLoad (srcLoad),
    .srcData (srcData),
    .destQ   (destQ),
    .srcQ    (srcQ)
  );

  // R1: reset leaves everything cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> ((destQ == '0) && (srcQ == '0) && !multiHotErr));

endmodule

// File: tb/test_strobe_bus_mover.sv
module test_strobe_bus_mover;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  timing;
  logic [3:0]  srcLoad;
  logic [31:0] srcData;
  logic        swapReq;
  logic [7:0]  destQ;
  logic [31:0] srcQ;
  logic        multiHotErr;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mSrc [4];
  logic [7:0] mDest;
  logic       mErr;

  always #2 clk = ~clk;

  strobe_bus_mover i_strobe_bus_mover (
    .clk(clk), .rst(rst), .timing(timing), .srcLoad(srcLoad),
    .srcData(srcData), .swapReq(swapReq), .destQ(destQ),
    .srcQ(srcQ), .multiHotErr(multiHotErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " dest"}, {24'd0, destQ}, {24'd0, mDest});
    chk({tag, " src"}, srcQ, {mSrc[3], mSrc[2], mSrc[1], mSrc[0]});
    chk({tag, " err"}, {31'd0, multiHotErr}, {31'd0, mErr});
  endtask

  // Apply one cycle of stimulus at a falling edge, update the model
  task automatic step(input logic [3:0] t, input logic [3:0] ld,
                      input logic [31:0] d, input logic sw);
    logic [7:0] old [4];
    timing = t; srcLoad = ld; srcData = d; swapReq = sw;
    @(posedge clk);
    for (int i = 0; i < 4; i++) old[i] = mSrc[i];
    mErr = ($countones(t) > 1);
    if ($countones(t) == 1) begin
      for (int i = 0; i < 4; i++) if (t[i]) mDest = old[i];
    end
    for (int i = 0; i < 4; i++) begin
      if (ld[i]) mSrc[i] = d[i*8 +: 8];
      else if (sw && i == 1) mSrc[i] = old[2];
      else if (sw && i == 2) mSrc[i] = old[1];
    end
    @(negedge clk);
    timing = '0; srcLoad = '0; srcData = '0; swapReq = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) mSrc[i] = '0;
    mDest = '0; mErr = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    checkAll("R1 reset");
  endtask

  task automatic testPreload();
    step(4'h0, 4'hF, 32'hD4_C3_B2_A1, 1'b0);
    checkAll("R6 preload");
  endtask

  task automatic testSingles();
    for (int i = 0; i < 4; i++) begin
      step(4'(1 << i), 4'h0, 32'h0, 1'b0);
      checkAll($sformatf("R2 R3 single T%0d", i));
    end
    step(4'h2, 4'h0, 32'h0, 1'b0);
    checkAll("R2 back to source 1");
  endtask

  task automatic testIdle();
    step(4'h0, 4'h0, 32'h0, 1'b0);
    checkAll("R4 idle hold");
    step(4'h0, 4'h0, 32'h0, 1'b0);
    checkAll("R4 idle hold again");
  endtask

  task automatic testConflict();
    step(4'h5, 4'h0, 32'h0, 1'b0);
    checkAll("R5 two strobes");
    step(4'hF, 4'h0, 32'h0, 1'b0);
    checkAll("R5 four strobes");
    step(4'h0, 4'h0, 32'h0, 1'b0);
    checkAll("R5 flag clears");
  endtask

  task automatic testSwap();
    step(4'h0, 4'h0, 32'h0, 1'b1);
    checkAll("R7 swap");
    step(4'h4, 4'h0, 32'h0, 1'b0);
    checkAll("R7 R2 copy swapped source 2");
  endtask

  task automatic testSwapPriority();
    step(4'h0, 4'h2, 32'h0000_5A00, 1'b1);
    checkAll("R8 load wins on source 1");
    step(4'h0, 4'h4, 32'h0066_0000, 1'b1);
    checkAll("R8 load wins on source 2");
  endtask

  task automatic testSameCycle();
    step(4'h8, 4'h8, 32'h7E00_0000, 1'b0);
    checkAll("R9 old value transferred");
    step(4'h8, 4'h0, 32'h0, 1'b0);
    checkAll("R9 new value next time");
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; timing = '0; srcLoad = '0; srcData = '0; swapReq = 1'b0;
    @(negedge clk);
    testReset();
    testPreload();
    testSingles();
    testIdle();
    testConflict();
    testSwap();
    testSwapPriority();
    testSameCycle();
    testReset();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule